// File: doc/BRIEF.md
# Masked Content-Addressable Memory Array with Entry Validity

This block holds a small content-addressable memory: by default 16 words of 64 bits, each tagged with a 2-bit validity state. A search key is compared against every stored word in one clock. Bit positions can be excluded from the search through one of two mask registers. Bits that belong to the RAM part of the word are also excluded. The first matching word in index order is reported as the match address, and a match flag says whether any word matched at all.

Each word can be split into an upper searchable part and a lower RAM part, in 16-bit steps. The RAM part keeps data associated with the key in the same word. A search can follow automatic rules, in which only Valid words take part, or it can be forced onto one chosen validity state. A forced search for Empty words ignores the data and finds free slots.

Direct writes place a word and its validity state. The target is an explicit index, a loadable address register, the lowest free word, or the last match address. A write mask can keep selected bits of the old word. A combinational read port returns any word and its state.

Top module: `cam_array`

## Requirements
- R1: After reset every word has state Empty (code 10) and data 0, both mask registers are 0, `match_flag` is 0, `match_addr` is 0, `next_free` is 0 and `full` is 0.
- R2: When `cmp_go` is high with `cmp_forced` low, only words in state Valid (code 00) can match. `match_flag` and `match_addr` update at the next clock edge and hold their values until the next `cmp_go`.
- R3: `cmp_mask_sel` 01 applies mask register 0 and 10 applies mask register 1; 00 and 11 apply no mask. A mask bit of 1 removes that bit position from the search.
- R4: `split_sel` sets the RAM part of each word. Code 0 gives no RAM bits, 1 gives the low 16 bits, 2 the low 32 bits and 3 the low 48 bits; codes 4 to 7 act as code 0. RAM bits never take part in a search.
- R5: With `cmp_forced` high, only words whose state equals `cmp_cond` can match (Valid 00, Skip 01, Empty 10, Random-access 11). A forced search for Empty ignores every data bit, so it hits every Empty word.
- R6: `match_addr` is the lowest-numbered matching word, and it is 0 when nothing matched.
- R7: `next_free` is the lowest-numbered word in state Empty. `full` is high and `next_free` is 0 when no word is Empty. Both follow the stored states with no added latency.
- R8: A write with `wr_en` stores `wr_data` and sets the state to `wr_state` at the word chosen by `wr_mode`: 00 `wr_addr`, 01 the address register (loaded from `ar_data` by `ar_load`), 10 `next_free`, 11 `match_addr`.
- R9: `wr_mask_sel` (01 mask 0, 10 mask 1, else none) keeps the old word's bit wherever the selected mask bit is 1.
- R10: A write in mode 10 while `full` is high, or in mode 11 while `match_flag` is low, changes nothing.
- R11: `rd_data` and `rd_state` show the stored word and state at `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| split_sel | input | 3 | Searchable/RAM partition code |
| cmp_mask_sel | input | 2 | Mask register used by searches |
| mask_wr_en | input | 1 | Load a mask register |
| mask_wr_idx | input | 1 | Which mask register to load |
| mask_wr_data | input | WIDTH | New mask value |
| ar_load | input | 1 | Load the address register |
| ar_data | input | AW | New address register value |
| cmp_go | input | 1 | Start a search this cycle |
| cmp_forced | input | 1 | Search one chosen validity state |
| cmp_cond | input | 2 | State searched when forced |
| cmp_key | input | WIDTH | Search key |
| wr_en | input | 1 | Direct write |
| wr_mode | input | 2 | Write target selection |
| wr_addr | input | AW | Explicit write index |
| wr_data | input | WIDTH | Write data |
| wr_state | input | 2 | Validity state written |
| wr_mask_sel | input | 2 | Mask applied to the write |
| rd_addr | input | AW | Read index |
| rd_data | output | WIDTH | Stored word at `rd_addr` |
| rd_state | output | 2 | Stored state at `rd_addr` |
| match_flag | output | 1 | Last search found a word |
| match_addr | output | AW | Lowest matching index |
| next_free | output | AW | Lowest Empty index |
| full | output | 1 | No Empty word exists |

## Verification
The assertions check on every cycle that the search result holds between searches and that a cleared flag comes with a zero address. They also check that a forced Empty search agrees with the free-word outputs, and that writes to the free word or the match word land where those outputs pointed. A write aimed at a full array must leave the storage untouched. The bench scenarios are the only place the data side can be shown. They cover the partition codes and the mask selection, which one of several hits wins, and how masked writes merge with old bits. The bench's random traffic uses a small pool of word patterns, so hits and multiple hits are common.

// File: rtl/cam_pkg.sv
package cam_pkg;

    typedef enum logic [1:0] {
        VS_VALID  = 2'b00,
        VS_SKIP   = 2'b01,
        VS_EMPTY  = 2'b10,
        VS_RANDOM = 2'b11
    } vstate_e;

    typedef enum logic [1:0] {
        WA_EXPLICIT = 2'b00,
        WA_AREG     = 2'b01,
        WA_FREE     = 2'b10,
        WA_MATCH    = 2'b11
    } waddr_e;

    localparam logic [1:0] MSEL_A = 2'b01;
    localparam logic [1:0] MSEL_B = 2'b10;

endpackage

// File: rtl/cam_entry_match.sv
module cam_entry_match #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] entry,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] care,
    input  logic [1:0]       ent_state,
    input  logic [1:0]       want_state,
    output logic             hit
);
    logic [WIDTH-1:0] diff;

    always_comb begin
        diff = (entry ^ key) & care;
        hit  = (ent_state == want_state) && (diff == '0);
    end
endmodule

// File: rtl/cam_first_set.sv
module cam_first_set #(
    parameter int N  = 16,
    parameter int AW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [AW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = AW'(i);
            end
        end
    end
endmodule

// File: rtl/cam_array.sv
module cam_array
    import cam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    parameter int SEG   = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       split_sel,
    input  logic [1:0]       cmp_mask_sel,
    input  logic             mask_wr_en,
    input  logic             mask_wr_idx,
    input  logic [WIDTH-1:0] mask_wr_data,
    input  logic             ar_load,
    input  logic [AW-1:0]    ar_data,
    input  logic             cmp_go,
    input  logic             cmp_forced,
    input  logic [1:0]       cmp_cond,
    input  logic [WIDTH-1:0] cmp_key,
    input  logic             wr_en,
    input  logic [1:0]       wr_mode,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       wr_state,
    input  logic [1:0]       wr_mask_sel,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic [1:0]       rd_state,
    output logic             match_flag,
    output logic [AW-1:0]    match_addr,
    output logic [AW-1:0]    next_free,
    output logic             full
);
    localparam int NSEG = WIDTH / SEG;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [DEPTH-1:0][1:0]       vld;
        logic [1:0][WIDTH-1:0]       mask;
        logic [AW-1:0]               areg;
        logic                        mflag;
        logic [AW-1:0]               maddr;
    } st_t;

    st_t s_d, s_q;

    function automatic st_t reset_state();
        st_t r;
        r = '0;
        for (int i = 0; i < DEPTH; i++) r.vld[i] = VS_EMPTY;
        return r;
    endfunction

    // search qualifiers
    logic [WIDTH-1:0] srch_mask_d, cam_part_d, care_d;
    logic [1:0]       want_d;
    int               ram_segs_d;

    always_comb begin
        case (cmp_mask_sel)
            MSEL_A:  srch_mask_d = s_q.mask[0];
            MSEL_B:  srch_mask_d = s_q.mask[1];
            default: srch_mask_d = '0;
        endcase
        ram_segs_d = split_sel[2] ? 0 : int'(split_sel[1:0]);
        if (ram_segs_d > NSEG - 1) ram_segs_d = NSEG - 1;
        cam_part_d = {WIDTH{1'b1}} << (ram_segs_d * SEG);
        care_d     = cam_part_d & ~srch_mask_d;
        want_d     = cmp_forced ? cmp_cond : VS_VALID;
        if (cmp_forced && (cmp_cond == VS_EMPTY)) care_d = '0;
    end

    // per-entry comparators
    logic [DEPTH-1:0] hit_vec, empty_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        cam_entry_match #(.WIDTH(WIDTH)) u_match (
            .entry      (s_q.mem[g]),
            .key        (cmp_key),
            .care       (care_d),
            .ent_state  (s_q.vld[g]),
            .want_state (want_d),
            .hit        (hit_vec[g])
        );
        assign empty_vec[g] = (s_q.vld[g] == VS_EMPTY);
    end

    logic          hit_any, has_free;
    logic [AW-1:0] hit_idx, free_idx;

    cam_first_set #(.N(DEPTH), .AW(AW)) u_hit_prio (
        .req   (hit_vec),
        .found (hit_any),
        .idx   (hit_idx)
    );

    cam_first_set #(.N(DEPTH), .AW(AW)) u_free_prio (
        .req   (empty_vec),
        .found (has_free),
        .idx   (free_idx)
    );

    // write target
    logic [AW-1:0]    wr_tgt_d;
    logic             wr_ok_d;
    logic [WIDTH-1:0] wr_keep_d;

    always_comb begin
        wr_tgt_d = wr_addr;
        wr_ok_d  = wr_en;
        case (waddr_e'(wr_mode))
            WA_EXPLICIT: wr_tgt_d = wr_addr;
            WA_AREG:     wr_tgt_d = s_q.areg;
            WA_FREE: begin
                wr_tgt_d = free_idx;
                wr_ok_d  = wr_en && has_free;
            end
            WA_MATCH: begin
                wr_tgt_d = s_q.maddr;
                wr_ok_d  = wr_en && s_q.mflag;
            end
            default: wr_tgt_d = wr_addr;
        endcase
        case (wr_mask_sel)
            MSEL_A:  wr_keep_d = s_q.mask[0];
            MSEL_B:  wr_keep_d = s_q.mask[1];
            default: wr_keep_d = '0;
        endcase
    end

    // next state
    always_comb begin
        s_d = s_q;
        if (mask_wr_en) s_d.mask[mask_wr_idx] = mask_wr_data;
        if (ar_load)    s_d.areg = ar_data;
        if (cmp_go) begin
            s_d.mflag = hit_any;
            s_d.maddr = hit_any ? hit_idx : '0;
        end
        if (wr_ok_d) begin
            s_d.mem[wr_tgt_d] = (s_q.mem[wr_tgt_d] & wr_keep_d) | (wr_data & ~wr_keep_d);
            s_d.vld[wr_tgt_d] = wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= reset_state();
        else        s_q <= s_d;
    end

    assign rd_data    = s_q.mem[rd_addr];
    assign rd_state   = s_q.vld[rd_addr];
    assign match_flag = s_q.mflag;
    assign match_addr = s_q.maddr;
    assign next_free  = has_free ? free_idx : '0;
    assign full       = !has_free;

    // R2: result held between searches
    a_r2_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_go |=> ($stable(match_flag) && $stable(match_addr)));

    // R6: no match reports index zero
    a_r6_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !match_flag |-> (match_addr == '0));

    // R5: forced Empty search agrees with free-word tracking
    a_r5_empty_search: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && cmp_forced && (cmp_cond == VS_EMPTY))
        |=> ((match_flag == !$past(full)) && (match_addr == $past(next_free))));

    // R7: write to the free word lands at next_free
    a_r7_free_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_mode == WA_FREE) && !full)
        |=> (s_q.vld[$past(next_free)] == $past(wr_state)));

    // R8: write to the match word lands at match_addr
    a_r8_match_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_mode == WA_MATCH) && match_flag)
        |=> (s_q.vld[$past(match_addr)] == $past(wr_state)));

    // R10: free-word write into a full array changes nothing
    a_r10_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_mode == WA_FREE) && full)
        |=> ($stable(s_q.vld) && $stable(s_q.mem)));

endmodule

// File: tb/sim_cam_array.sv
`timescale 1ns/1ps
module sim_cam_array;
    localparam int DEPTH = 16;
    localparam int WIDTH = 64;
    localparam int AW = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       split_sel = '0;
    logic [1:0]       cmp_mask_sel = '0;
    logic             mask_wr_en = 1'b0;
    logic             mask_wr_idx = 1'b0;
    logic [WIDTH-1:0] mask_wr_data = '0;
    logic             ar_load = 1'b0;
    logic [AW-1:0]    ar_data = '0;
    logic             cmp_go = 1'b0;
    logic             cmp_forced = 1'b0;
    logic [1:0]       cmp_cond = '0;
    logic [WIDTH-1:0] cmp_key = '0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_mode = '0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [1:0]       wr_state = '0;
    logic [1:0]       wr_mask_sel = '0;
    logic [AW-1:0]    rd_addr = '0;
    logic [WIDTH-1:0] rd_data;
    logic [1:0]       rd_state;
    logic             match_flag;
    logic [AW-1:0]    match_addr;
    logic [AW-1:0]    next_free;
    logic             full;

    always #10 clk = ~clk;

    cam_array u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model
    logic [WIDTH-1:0] m_mem [DEPTH];
    logic [1:0]       m_vld [DEPTH];
    logic [WIDTH-1:0] m_mask [2];
    logic [AW-1:0]    m_ar;
    logic             m_flag;
    logic [AW-1:0]    m_addr;

    logic [WIDTH-1:0] pats [4] = '{64'hCAFE_0000_0000_1234, 64'h0123_4567_89AB_CDEF,
                                   64'hFFFF_0000_FFFF_0000, 64'h0};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int mfree();
        for (int i = 0; i < DEPTH; i++) if (m_vld[i] == 2'b10) return i;
        return -1;
    endfunction

    function automatic logic [WIDTH-1:0] sel_mask(input logic [1:0] s);
        if (s == 2'b01) return m_mask[0];
        if (s == 2'b10) return m_mask[1];
        return '0;
    endfunction

    function automatic int mhit();
        logic [WIDTH-1:0] care;
        logic [1:0] want;
        int ram;
        ram  = split_sel[2] ? 0 : int'(split_sel[1:0]) * 16;
        care = ({WIDTH{1'b1}} << ram) & ~sel_mask(cmp_mask_sel);
        want = cmp_forced ? cmp_cond : 2'b00;
        if (cmp_forced && cmp_cond == 2'b10) care = '0;
        for (int i = 0; i < DEPTH; i++)
            if (m_vld[i] == want && ((m_mem[i] ^ cmp_key) & care) == '0) return i;
        return -1;
    endfunction

    task automatic check_outputs();
        int f;
        f = mfree();
        chk("R2 R6 match_flag", 64'(match_flag), 64'(m_flag));
        chk("R6 match_addr", 64'(match_addr), 64'(m_addr));
        chk("R7 next_free", 64'(next_free), (f < 0) ? 64'd0 : 64'(f));
        chk("R7 full", 64'(full), 64'(f < 0));
        rd_addr = AW'($urandom % DEPTH);
        #1;
        chk("R11 rd_data", rd_data, m_mem[rd_addr]);
        chk("R11 rd_state", 64'(rd_state), 64'(m_vld[rd_addr]));
    endtask

    task automatic cycle();
        logic [WIDTH-1:0] n_mem [DEPTH];
        logic [1:0]       n_vld [DEPTH];
        logic [WIDTH-1:0] n_mask [2];
        logic [AW-1:0]    n_ar, n_addr, tgt;
        logic             n_flag, ok;
        logic [WIDTH-1:0] keep;
        int h, f;
        n_mem = m_mem; n_vld = m_vld; n_mask = m_mask;
        n_ar = m_ar; n_flag = m_flag; n_addr = m_addr;
        if (mask_wr_en) n_mask[mask_wr_idx] = mask_wr_data;
        if (ar_load) n_ar = ar_data;
        if (cmp_go) begin
            h = mhit();
            n_flag = (h >= 0);
            n_addr = (h >= 0) ? AW'(h) : '0;
        end
        if (wr_en) begin
            f = mfree();
            ok = 1'b1;
            tgt = wr_addr;
            case (wr_mode)
                2'b01: tgt = m_ar;
                2'b10: begin tgt = (f < 0) ? '0 : AW'(f); ok = (f >= 0); end
                2'b11: begin tgt = m_addr; ok = m_flag; end
                default: tgt = wr_addr;
            endcase
            keep = sel_mask(wr_mask_sel);
            if (ok) begin
                n_mem[tgt] = (m_mem[tgt] & keep) | (wr_data & ~keep);
                n_vld[tgt] = wr_state;
            end
        end
        @(posedge clk);
        @(negedge clk);
        m_mem = n_mem; m_vld = n_vld; m_mask = n_mask;
        m_ar = n_ar; m_flag = n_flag; m_addr = n_addr;
        mask_wr_en = 0; ar_load = 0; cmp_go = 0; wr_en = 0;
        check_outputs();
    endtask

    task automatic do_write(input logic [1:0] mode, input logic [AW-1:0] a,
                            input logic [63:0] d, input logic [1:0] st, input logic [1:0] ms);
        wr_en = 1; wr_mode = mode; wr_addr = a; wr_data = d; wr_state = st; wr_mask_sel = ms;
        cycle();
    endtask

    task automatic do_cmp(input logic forced, input logic [1:0] cond, input logic [63:0] key,
                          input logic [2:0] sp, input logic [1:0] ms);
        cmp_go = 1; cmp_forced = forced; cmp_cond = cond; cmp_key = key;
        split_sel = sp; cmp_mask_sel = ms;
        cycle();
    endtask

    task automatic peek(input string req, input logic [AW-1:0] a,
                        input logic [63:0] d, input logic [1:0] st);
        rd_addr = a;
        #1;
        chk(req, rd_data, d);
        chk(req, 64'(rd_state), 64'(st));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_vld[i] = 2'b10; end
        m_mask[0] = '0; m_mask[1] = '0; m_ar = '0; m_flag = 0; m_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 match_flag", 64'(match_flag), 64'd0);
        chk("R1 match_addr", 64'(match_addr), 64'd0);
        chk("R1 next_free", 64'(next_free), 64'd0);
        chk("R1 full", 64'(full), 64'd0);
        for (int i = 0; i < DEPTH; i++) peek("R1 entry", AW'(i), 64'd0, 2'b10);
        // R5: forced Empty search hits word 0
        do_cmp(1, 2'b10, 64'h1234, 3'd0, 2'b00);
        chk("R5 empty hit flag", 64'(match_flag), 64'd1);
        // R2: automatic search with no Valid word
        do_cmp(0, 2'b00, 64'h0, 3'd0, 2'b00);
        chk("R2 no valid flag", 64'(match_flag), 64'd0);
        chk("R6 no hit addr", 64'(match_addr), 64'd0);
        // R10: match-address write with no match is dropped
        do_write(2'b11, '0, 64'h55, 2'b00, 2'b00);
        peek("R10 no-match write", 4'd0, 64'd0, 2'b10);
        // R7: fill via free-word writes
        for (int i = 0; i < DEPTH; i++) begin
            chk("R7 free index", 64'(next_free), 64'(i));
            do_write(2'b10, '0, 64'h1000_0000_0000_0000 + 64'(i), 2'b00, 2'b00);
        end
        chk("R7 full set", 64'(full), 64'd1);
        chk("R7 free zero when full", 64'(next_free), 64'd0);
        // R10: write into full array is dropped
        do_write(2'b10, '0, 64'hDEAD, 2'b00, 2'b00);
        peek("R10 full write", 4'd0, 64'h1000_0000_0000_0000, 2'b00);
        // R4: partition
        do_write(2'b00, 4'd5, 64'hCAFE_0000_0000_1234, 2'b00, 2'b00);
        do_write(2'b00, 4'd3, 64'hCAFE_0000_0000_EDCB, 2'b00, 2'b00);
        do_cmp(0, 2'b00, 64'hCAFE_0000_0000_1234, 3'd1, 2'b00);
        chk("R4 split1 addr", 64'(match_addr), 64'd3);
        do_cmp(0, 2'b00, 64'hCAFE_0000_0000_1234, 3'd0, 2'b00);
        chk("R4 split0 addr", 64'(match_addr), 64'd5);
        do_cmp(0, 2'b00, 64'hCAFE_0000_0000_1234, 3'd5, 2'b00);
        chk("R4 split5 addr", 64'(match_addr), 64'd5);
        // R3: mask selection
        mask_wr_en = 1; mask_wr_idx = 0; mask_wr_data = 64'hFFFF; cycle();
        do_cmp(0, 2'b00, 64'hCAFE_0000_0000_1234, 3'd0, 2'b01);
        chk("R3 mask0 addr", 64'(match_addr), 64'd3);
        do_cmp(0, 2'b00, 64'hCAFE_0000_0000_1234, 3'd0, 2'b11);
        chk("R3 mask none addr", 64'(match_addr), 64'd5);
        // R9: masked write keeps low 16 bits
        do_write(2'b00, 4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 2'b00, 2'b01);
        peek("R9 masked write", 4'd7, 64'hFFFF_FFFF_FFFF_0007, 2'b00);
        // R8: address register target
        ar_load = 1; ar_data = 4'd9; cycle();
        do_write(2'b01, '0, 64'h99, 2'b01, 2'b00);
        peek("R8 areg write", 4'd9, 64'h99, 2'b01);
        do_cmp(1, 2'b01, 64'h99, 3'd0, 2'b00);
        chk("R5 skip search flag", 64'(match_flag), 64'd1);
        chk("R5 skip search addr", 64'(match_addr), 64'd9);
        do_write(2'b11, '0, 64'h77, 2'b11, 2'b00);
        peek("R8 match write", 4'd9, 64'h77, 2'b11);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom % 10;
            split_sel = 3'($urandom);
            if (r == 0) begin
                mask_wr_en = 1; mask_wr_idx = 1'($urandom);
                for (int l = 0; l < 4; l++)
                    mask_wr_data[l*16 +: 16] = ($urandom % 3 == 0) ? 16'hFFFF :
                                               ($urandom % 2 == 0) ? 16'h0 : 16'($urandom);
                cycle();
            end else if (r == 1) begin
                ar_load = 1; ar_data = AW'($urandom); cycle();
            end else if (r < 6) begin
                logic [63:0] d;
                d = pats[$urandom % 4];
                if ($urandom % 3 == 0) d = d ^ (64'h1 << ($urandom % 64));
                do_write(2'($urandom), AW'($urandom), d,
                         ($urandom % 4 == 0) ? 2'b10 : 2'($urandom), 2'($urandom));
            end else begin
                logic [63:0] k;
                k = m_mem[$urandom % DEPTH];
                if ($urandom % 4 == 0) k = k ^ (64'h1 << ($urandom % 64));
                do_cmp(1'($urandom), 2'($urandom), k, 3'($urandom), 2'($urandom));
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule